// File: doc/BRIEF.md
# CPU Clock Pair Stop and Power-Down Gate

This block decides, for each of three differential CPU clock output pairs, whether the pair passes the running clock, holds a parked level, or releases both of its drivers. It reads two active-low pins, power-down (`pdN`) and stop request (`stopN`). It also reads a set of control bits that a register elsewhere holds: a per-pair enable, a per-pair free-run exemption, a tri-state choice for power-down and a tri-state choice for stop. From these it drives, per pair, the true-side level, the complement-side level, a drive enable for each side, a running flag and a tri-state flag.

The block uses one of three modes for each pair. In run mode the pair follows `srcClk`. In park mode the true side is high and the complement side is low, both driven. In high-impedance mode both drivers are off and both levels read 0. The mode is held in a register. A new mode is taken only on a `clk` edge where the source clock `srcClk` is low, so a pair never starts or stops mid-pulse. The source clock is an input synchronous to `clk`. Priority from highest to lowest: power-down, then a disabled pair, then the stop request, then free-running.

Top module: `cpuClkGate`

## Requirements
- R1: After reset, and until the first `clk` edge with `srcClk` low, every pair is parked: trueLvl=1, compLvl=0, trueDrv=compDrv=1, pairRun=0, pairHiz=0.
- R2: A running pair has trueLvl equal to `srcClk` and compLvl equal to its inverse, with both drivers on and pairRun=1.
- R3: With `pdN`=0 and both tri-state choice bits 0, every pair is parked (true high, complement low, both driven), including disabled pairs.
- R4: With `pdN`=0 and `pdTriSel`=1, every pair is high-impedance: both drive enables 0 and pairHiz=1.
- R5: With `pdN`=0, `pdTriSel`=0 and `stopTriSel`=1, every pair is high-impedance.
- R6: With `pdN`=1, `stopN`=0 and `stopTriSel`=0, an enabled pair whose freeRun bit is 1 keeps running, and one whose freeRun bit is 0 is parked.
- R7: With `pdN`=1, `stopN`=0 and `stopTriSel`=1, every enabled pair is high-impedance, free-running ones included.
- R8: `pdTriSel` has no effect while power-down is deasserted: the stop outcome of R6 is the same with it set.
- R9: With `pdN`=1, a pair whose `pairEn` bit is 0 is parked, whether or not the stop request is asserted.
- R10: Power-down takes priority over disable: under R4 conditions a disabled pair is also high-impedance.
- R11: A pair's mode changes only on a `clk` edge where `srcClk` is low. With `srcClk` high the mode holds, whatever the inputs do.
- R12: A high-impedance pair reports trueLvl=0 and compLvl=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcClk | input | 1 | Level of the running CPU clock, synchronous to clk |
| pdN | input | 1 | Power-down, active low |
| stopN | input | 1 | Stop request, active low |
| pdTriSel | input | 1 | 1: tri-state all pairs in power-down |
| stopTriSel | input | 1 | 1: tri-state on stop, and also in power-down |
| freeRun | input | 3 | Per-pair exemption from the stop request |
| pairEn | input | 3 | Per-pair enable, 0 parks the pair |
| trueLvl | output | 3 | True-side level per pair |
| compLvl | output | 3 | Complement-side level per pair |
| trueDrv | output | 3 | True-side drive enable per pair |
| compDrv | output | 3 | Complement-side drive enable per pair |
| pairRun | output | 3 | 1 when the pair is running |
| pairHiz | output | 3 | 1 when the pair is tri-stated |

## Verification
Two pairs of conditions can land in the same cycle. The first is a stop request together with power-down. The second is a disable together with either of them. In each case the priority order decides which outcome wins. The bench applies these combinations in the same cycle: power-down with a disabled pair, a stop request with free-running and disabled pairs, and the power-down choice bit set while only a stop is active. It then checks which mode each pair reports. A second race is the mode change against the phase of the source clock. The bench changes the stop pin while `srcClk` is high and checks that no pair moves until the first edge where the clock is low.

// File: rtl/cg_pkg.sv
package cg_pkg;
  parameter int unsigned PAIRS = 3;

  typedef enum logic [1:0] {
    MODE_PARK = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_HIZ  = 2'd2
  } pairMode_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic [PAIRS-1:0]      load;
    pairMode_t [PAIRS-1:0] target;
  } gateStrobe_t;
endpackage

// File: rtl/cg_ctrl.sv
module cg_ctrl
  import cg_pkg::*;
(
  input  logic                   srcClk,
  input  logic                   pdN,
  input  logic                   stopN,
  input  logic                   pdTriSel,
  input  logic                   stopTriSel,
  input  logic [PAIRS-1:0]       freeRun,
  input  logic [PAIRS-1:0]       pairEn,
  input  pairMode_t [PAIRS-1:0]  modeNow,
  output gateStrobe_t            strobe
);
  logic hizInPd;
  assign hizInPd = pdTriSel | stopTriSel;

  always_comb begin
    strobe = '0;
    for (int i = 0; i < PAIRS; i++) begin
      if (!pdN)
        strobe.target[i] = hizInPd ? MODE_HIZ : MODE_PARK;
      else if (!pairEn[i])
        strobe.target[i] = MODE_PARK;
      else if (!stopN && stopTriSel)
        strobe.target[i] = MODE_HIZ;
      else if (!stopN && !freeRun[i])
        strobe.target[i] = MODE_PARK;
      else
        strobe.target[i] = MODE_RUN;
      // switch only while the source clock sits low
      strobe.load[i] = !srcClk && (strobe.target[i] != modeNow[i]);
    end
  end
endmodule

// File: rtl/cg_datapath.sv
module cg_datapath
  import cg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  srcClk,
  input  gateStrobe_t           strobe,
  output pairMode_t [PAIRS-1:0] modeNow,
  output logic [PAIRS-1:0]      trueLvl,
  output logic [PAIRS-1:0]      compLvl,
  output logic [PAIRS-1:0]      trueDrv,
  output logic [PAIRS-1:0]      compDrv,
  output logic [PAIRS-1:0]      pairRun,
  output logic [PAIRS-1:0]      pairHiz
);
  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    pairMode_t modeQ;

    always_ff @(posedge clk) begin
      if (!rstN)
        modeQ <= MODE_PARK;
      else if (strobe.load[g])
        modeQ <= strobe.target[g];
    end

    assign modeNow[g] = modeQ;

    always_comb begin
      unique case (modeQ)
        MODE_RUN: begin
          trueLvl[g] = srcClk;  compLvl[g] = ~srcClk;
          trueDrv[g] = 1'b1;    compDrv[g] = 1'b1;
        end
        MODE_HIZ: begin
          trueLvl[g] = 1'b0;    compLvl[g] = 1'b0;
          trueDrv[g] = 1'b0;    compDrv[g] = 1'b0;
        end
        default: begin
          trueLvl[g] = 1'b1;    compLvl[g] = 1'b0;
          trueDrv[g] = 1'b1;    compDrv[g] = 1'b1;
        end
      endcase
      pairRun[g] = (modeQ == MODE_RUN);
      pairHiz[g] = (modeQ == MODE_HIZ);
    end

    // R11: mode moves only across an edge taken with the source clock low
    p_change_low_r11: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ != $past(modeQ)) |-> !$past(srcClk));
  end
endmodule

// File: rtl/cpuClkGate.sv
module cpuClkGate
  import cg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcClk,
  input  logic             pdN,
  input  logic             stopN,
  input  logic             pdTriSel,
  input  logic             stopTriSel,
  input  logic [PAIRS-1:0] freeRun,
  input  logic [PAIRS-1:0] pairEn,
  output logic [PAIRS-1:0] trueLvl,
  output logic [PAIRS-1:0] compLvl,
  output logic [PAIRS-1:0] trueDrv,
  output logic [PAIRS-1:0] compDrv,
  output logic [PAIRS-1:0] pairRun,
  output logic [PAIRS-1:0] pairHiz
);
  localparam logic [PAIRS-1:0] ALL = {PAIRS{1'b1}};

  gateStrobe_t           strobe;
  pairMode_t [PAIRS-1:0] modeNow;

  cg_ctrl u_ctrl (
    .srcClk(srcClk), .pdN(pdN), .stopN(stopN), .pdTriSel(pdTriSel),
    .stopTriSel(stopTriSel), .freeRun(freeRun), .pairEn(pairEn),
    .modeNow(modeNow), .strobe(strobe)
  );

  cg_datapath u_dp (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .strobe(strobe),
    .modeNow(modeNow), .trueLvl(trueLvl), .compLvl(compLvl),
    .trueDrv(trueDrv), .compDrv(compDrv), .pairRun(pairRun),
    .pairHiz(pairHiz)
  );

  // R4: power-down with its tri-state choice releases every pair
  p_pd_hiz_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!pdN && pdTriSel && !srcClk) |=> (pairHiz == ALL));

  // R3: plain power-down parks every pair
  p_pd_park_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!pdN && !pdTriSel && !stopTriSel && !srcClk)
      |=> (trueLvl == ALL && compLvl == '0 && pairRun == '0));

  // R9: outside power-down a disabled pair sits parked
  p_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pdN && !srcClk) |=> (((~$past(pairEn)) & ~(trueLvl & ~compLvl & trueDrv)) == '0));

  // R6: enabled free-running pairs keep running through a parking stop
  p_freerun_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pdN && !stopN && !stopTriSel && !srcClk)
      |=> (($past(pairEn) & $past(freeRun) & ~pairRun) == '0));
endmodule

// File: tb/tb_cpuClkGate.sv
module tb_cpuClkGate;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, srcClk = 1'b1;
  logic pdN = 1'b1, stopN = 1'b1, pdTriSel = 1'b0, stopTriSel = 1'b0;
  logic [2:0] freeRun = 3'b000, pairEn = 3'b111;
  logic [2:0] trueLvl, compLvl, trueDrv, compDrv, pairRun, pairHiz;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cpuClkGate dut (
    .clk(clk), .rstN(rstN), .srcClk(srcClk), .pdN(pdN), .stopN(stopN),
    .pdTriSel(pdTriSel), .stopTriSel(stopTriSel), .freeRun(freeRun),
    .pairEn(pairEn), .trueLvl(trueLvl), .compLvl(compLvl),
    .trueDrv(trueDrv), .compDrv(compDrv), .pairRun(pairRun),
    .pairHiz(pairHiz)
  );

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chkAll(input string req, input logic [2:0] eT, input logic [2:0] eC,
                        input logic [2:0] eD, input logic [2:0] eR, input logic [2:0] eH);
    chk({req, " trueLvl"}, trueLvl, eT);
    chk({req, " compLvl"}, compLvl, eC);
    chk({req, " trueDrv"}, trueDrv, eD);
    chk({req, " compDrv"}, compDrv, eD);
    chk({req, " pairRun"}, pairRun, eR);
    chk({req, " pairHiz"}, pairHiz, eH);
  endtask

  // one edge with the source clock low, then sample at the falling edge
  task automatic settle();
    srcClk = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setIn(input logic p, input logic s, input logic pt, input logic st,
                       input logic [2:0] fr, input logic [2:0] en);
    @(negedge clk);
    pdN = p; stopN = s; pdTriSel = pt; stopTriSel = st; freeRun = fr; pairEn = en;
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chkAll("R1", 3'b111, 3'b000, 3'b111, 3'b000, 3'b000);
  endtask

  task automatic tRun();
    setIn(1, 1, 0, 0, 3'b000, 3'b111);
    settle();
    chkAll("R2 low", 3'b000, 3'b111, 3'b111, 3'b111, 3'b000);
    srcClk = 1'b1; #1;
    chkAll("R2 high", 3'b111, 3'b000, 3'b111, 3'b111, 3'b000);
  endtask

  task automatic tPdPark();
    setIn(0, 1, 0, 0, 3'b000, 3'b101);
    settle();
    chkAll("R3", 3'b111, 3'b000, 3'b111, 3'b000, 3'b000);
  endtask

  task automatic tPdHiz();
    setIn(0, 1, 1, 0, 3'b000, 3'b111);
    settle();
    chkAll("R4 R12", 3'b000, 3'b000, 3'b000, 3'b000, 3'b111);
    setIn(0, 1, 0, 1, 3'b000, 3'b111);
    settle();
    chkAll("R5", 3'b000, 3'b000, 3'b000, 3'b000, 3'b111);
    setIn(0, 0, 1, 0, 3'b111, 3'b010);
    settle();
    chkAll("R10", 3'b000, 3'b000, 3'b000, 3'b000, 3'b111);
  endtask

  task automatic tStop();
    setIn(1, 0, 0, 0, 3'b101, 3'b111);
    settle();
    chkAll("R6", 3'b010, 3'b101, 3'b111, 3'b101, 3'b000);
    setIn(1, 0, 1, 0, 3'b101, 3'b111);
    settle();
    chkAll("R8", 3'b010, 3'b101, 3'b111, 3'b101, 3'b000);
    setIn(1, 0, 0, 1, 3'b101, 3'b111);
    settle();
    chkAll("R7", 3'b000, 3'b000, 3'b000, 3'b000, 3'b111);
  endtask

  task automatic tDisable();
    setIn(1, 0, 0, 1, 3'b000, 3'b011);
    settle();
    chkAll("R9 stop", 3'b100, 3'b000, 3'b100, 3'b000, 3'b011);
    setIn(1, 1, 0, 0, 3'b000, 3'b110);
    settle();
    chkAll("R9 run", 3'b001, 3'b110, 3'b111, 3'b110, 3'b000);
  endtask

  task automatic tPhase();
    setIn(1, 1, 0, 0, 3'b000, 3'b111);
    settle();
    chk("R11 start", pairRun, 3'b111);
    srcClk = 1'b1;
    setIn(1, 0, 0, 0, 3'b000, 3'b111);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R11 held high", pairRun, 3'b111);
    chk("R11 held lvl", trueLvl, 3'b111);
    settle();
    chk("R11 after low", pairRun, 3'b000);
    chk("R11 parked", trueLvl, 3'b111);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    tReset();
    tRun();
    tPdPark();
    tPdHiz();
    tStop();
    tDisable();
    tPhase();
    finishRun();
  end

  initial begin
    #(PERIOD * 5000);
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end
endmodule